// File: doc/BRIEF.md
# Escalating Watchdog Timer

This block is a per-core watchdog that does not reset the chip on the first missed deadline. Instead it escalates, one period at a time. The first missed period raises a maskable interrupt. The second raises a non-maskable interrupt. The third issues a one-cycle chip-wide soft-reset request. Software keeps it quiet by strobing a poke input before each period runs out. A poke returns the block to its idle stage and restarts the period.

The period is set by a configuration word with two fields. The length field supplies the high bits of a down-counter whose low bits start at zero. That counter steps once per prescaler wrap. With the default parameters this gives a 16-bit length feeding a 24-bit counter, stepped once every 256 clocks. The mode field sets the furthest stage the block may reach, and a mode of zero turns it off.

The current stage can be read back, so an NMI handler can tell whether this watchdog raised the NMI.

Top module: `wdt_escalate`

## Requirements
- R1: While reset is held, and after reset until the first configuration write, the block is disabled: stage 0, length 0, mode 0, and all three outputs low.
- R2: A configuration write stores the length and the mode, and both read back from the following cycle on. The same write clears the prescaler and the stage, and restarts the period from the new length. When the write strobe is low, the length and mode inputs have no effect.
- R3: With length L ≥ 1, each period lasts L·2^(FRAC_W+PRE_W) clocks, counted from the clear edge (configuration write or poke). The counter loads L into its high bits with the low FRAC_W bits at zero, and steps once per 2^PRE_W clocks. With L = 0, each period is 2^PRE_W clocks.
- R4: At the end of the first period with no poke, the stage becomes 1 and irq_o goes high. irq_o stays high until a poke or a configuration write.
- R5: At the end of the second period, the stage becomes 2 and nmi_o goes high. nmi_o stays high until a poke or a configuration write, and irq_o stays high with it.
- R6: At the end of the third period, the stage becomes 3 and soft_rst_o is high for exactly one cycle. After that the block holds stage 3 with irq_o and nmi_o high, and issues no further pulses.
- R7: Mode 1 stops at stage 1 and mode 2 stops at stage 2. A stage above the mode value is never reached and its output never asserts.
- R8: Mode 0 disables the block: the stage stays 0 and no output asserts.
- R9: A poke clears the stage and the irq_o and nmi_o outputs on the next edge. It then restarts a full period from the stored length.
- R10: rd_stage reads 0 for idle, 1 for interrupt, 2 for NMI and 3 for reset issued. Its bit 1 is set exactly when the NMI stage has been reached.
- R11: When a configuration write and a poke arrive in the same cycle, the configuration write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_len | input | LEN_W | Period length written on cfg_we |
| cfg_mode | input | 2 | Furthest enabled stage written on cfg_we (0 = off) |
| poke | input | 1 | Keep-alive strobe |
| irq_o | output | 1 | Interrupt level (stage ≥ 1) |
| nmi_o | output | 1 | Non-maskable interrupt level (stage ≥ 2) |
| soft_rst_o | output | 1 | One-cycle soft-reset request |
| rd_len | output | LEN_W | Stored length |
| rd_mode | output | 2 | Stored mode |
| rd_stage | output | 2 | Current stage |

## Verification
The assertions assume that cfg_we, poke, cfg_len and cfg_mode are synchronous to clk and stable around each edge. They do not assume that the stage ever falls back without one of the two clear strobes. The bench changes inputs only a little after each rising edge, and it drives random values on cfg_len and cfg_mode while cfg_we is low, so that ignored inputs are really exercised. Pokes and reconfigurations arrive at random points inside the escalation sequence, including in the same cycle as each other. The bench uses short prescaler and fraction widths so that full three-stage runs fit in the cycle budget.

// File: rtl/wdt_esc_pkg.sv
package wdt_esc_pkg;

    // Escalation stage; bit 1 flags that the NMI stage has been reached.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_IRQ  = 2'd1,
        ST_NMI  = 2'd2,
        ST_RST  = 2'd3
    } wdt_stage_e;

endpackage

// File: rtl/wdt_esc_prescale.sv
module wdt_esc_prescale #(
    parameter int PRE_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic tick
);
    localparam logic [PRE_W-1:0] PRE_LAST = {PRE_W{1'b1}};

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_s;

    pre_s pre_d, pre_q;

    always_comb begin
        pre_d = pre_q;
        tick  = 1'b0;
        if (clear) begin
            pre_d.cnt = '0;
        end else if (run) begin
            tick      = (pre_q.cnt == PRE_LAST);
            pre_d.cnt = pre_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    // R3: a tick occurs only after a clear-free run of the prescaler
    prescale_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !tick);

endmodule

// File: rtl/wdt_esc_count.sv
module wdt_esc_count #(
    parameter int LEN_W  = 16,
    parameter int FRAC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] load_len,
    input  logic [LEN_W-1:0] cur_len,
    input  logic             run,
    input  logic             tick,
    output logic             expire
);
    localparam int CNT_W = LEN_W + FRAC_W;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_s;

    cnt_s cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        expire = 1'b0;
        if (load) begin
            cnt_d.cnt = {load_len, {FRAC_W{1'b0}}};
        end else if (run && tick) begin
            if (cnt_q.cnt <= CNT_ONE) begin
                expire    = 1'b1;
                cnt_d.cnt = {cur_len, {FRAC_W{1'b0}}};
            end else begin
                cnt_d.cnt = cnt_q.cnt - CNT_ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R3
    expire_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> (tick && run));

endmodule

// File: rtl/wdt_esc_stage.sv
module wdt_esc_stage
    import wdt_esc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       expire,
    output wdt_stage_e stage,
    output logic       rst_pulse
);
    typedef struct packed {
        wdt_stage_e stage;
        logic       pulse;
    } stg_s;

    stg_s stg_d, stg_q;

    always_comb begin
        stg_d       = stg_q;
        stg_d.pulse = 1'b0;
        if (clear) begin
            stg_d.stage = ST_IDLE;
        end else if (expire && stg_q.stage != ST_RST) begin
            stg_d.stage = wdt_stage_e'(stg_q.stage + 2'd1);
            stg_d.pulse = (stg_q.stage == ST_NMI);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '{stage: ST_IDLE, pulse: 1'b0};
        else        stg_q <= stg_d;
    end

    assign stage     = stg_q.stage;
    assign rst_pulse = stg_q.pulse;

    // R6
    rst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse |=> !rst_pulse);

    // R6
    rst_in_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse |-> (stage == ST_RST));

    // R4
    stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !expire) |=> $stable(stage));

endmodule

// File: rtl/wdt_escalate.sv
module wdt_escalate
    import wdt_esc_pkg::*;
#(
    parameter int LEN_W  = 16,
    parameter int FRAC_W = 8,
    parameter int PRE_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic [1:0]       cfg_mode,
    input  logic             poke,
    output logic             irq_o,
    output logic             nmi_o,
    output logic             soft_rst_o,
    output logic [LEN_W-1:0] rd_len,
    output logic [1:0]       rd_mode,
    output logic [1:0]       rd_stage
);
    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic [1:0]       mode;
    } cfg_s;

    cfg_s cfg_d, cfg_q;

    logic             clear;
    logic             run;
    logic             tick;
    logic             expire;
    logic [LEN_W-1:0] load_len;
    wdt_stage_e       stage;
    logic             rst_pulse;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            cfg_d.len  = cfg_len;
            cfg_d.mode = cfg_mode;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign clear    = cfg_we | poke;
    assign load_len = cfg_we ? cfg_len : cfg_q.len;
    assign run      = (cfg_q.mode != 2'd0) && (2'(stage) < cfg_q.mode);

    wdt_esc_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clear),
        .run   (run),
        .tick  (tick)
    );

    wdt_esc_count #(.LEN_W(LEN_W), .FRAC_W(FRAC_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (clear),
        .load_len (load_len),
        .cur_len  (cfg_q.len),
        .run      (run),
        .tick     (tick),
        .expire   (expire)
    );

    wdt_esc_stage u_stg (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .expire    (expire),
        .stage     (stage),
        .rst_pulse (rst_pulse)
    );

    assign irq_o      = (stage != ST_IDLE);
    assign nmi_o      = stage[1];
    assign soft_rst_o = rst_pulse;
    assign rd_len     = cfg_q.len;
    assign rd_mode    = cfg_q.mode;
    assign rd_stage   = 2'(stage);

    // R7
    stage_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        2'(stage) <= cfg_q.mode);

    // R9
    clear_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we || poke) |=> (!irq_o && !nmi_o && !soft_rst_o));

    // R5
    nmi_has_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_o |-> irq_o);

    // R8
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.mode == 2'd0) |-> !irq_o);

endmodule

// File: tb/wdt_escalate_test.sv
module wdt_escalate_test;
    localparam int LW = 16;
    localparam int FW = 2;
    localparam int PW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [LW-1:0] cfg_len = '0;
    logic [1:0]    cfg_mode = '0;
    logic          poke = 1'b0;
    logic          irq_o, nmi_o, soft_rst_o;
    logic [LW-1:0] rd_len;
    logic [1:0]    rd_mode, rd_stage;

    int checks = 0;
    int fails  = 0;
    int mL = 0, mM = 0, k = 0;

    always #10 clk = ~clk;

    wdt_escalate #(.LEN_W(LW), .FRAC_W(FW), .PRE_W(PW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_len(cfg_len),
        .cfg_mode(cfg_mode), .poke(poke), .irq_o(irq_o), .nmi_o(nmi_o),
        .soft_rst_o(soft_rst_o), .rd_len(rd_len), .rd_mode(rd_mode),
        .rd_stage(rd_stage)
    );

    function automatic int per(int L);
        return (L == 0) ? (1 << PW) : L * (1 << (FW + PW));
    endfunction

    function automatic int exp_stage(int kk, int L, int M);
        int s = kk / per(L);
        if (s > M) s = M;
        return s;
    endfunction

    task automatic chk(string tag, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, got, exp, $time);
        end
    endtask

    task automatic cyc(bit we, int L, int M, bit pk);
        int es;
        string st;
        cfg_we = we; cfg_len = LW'(L); cfg_mode = 2'(M); poke = pk;
        @(posedge clk);
        #2;
        cfg_we = 1'b0; poke = 1'b0;
        if (we) begin mL = L; mM = M; k = 0; end
        else if (pk) k = 0;
        else k++;
        es = exp_stage(k, mL, mM);
        st = (mM == 0) ? "R8" : ((mM < 3) ? "R7" : "R10");
        chk(st,   "stage",    rd_stage, es);
        chk("R4", "irq",      irq_o, (es >= 1) ? 1 : 0);
        chk("R5", "nmi",      nmi_o, (es >= 2) ? 1 : 0);
        chk("R6", "soft_rst", soft_rst_o, (mM == 3 && k == 3 * per(mL)) ? 1 : 0);
        chk("R2", "len",      rd_len, mL);
        chk("R2", "mode",     rd_mode, mM);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(1'b0, int'($urandom_range(0, 65535)), int'($urandom_range(0, 3)), 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        #2;
        chk("R1", "irq in reset", irq_o, 0);
        chk("R1", "nmi in reset", nmi_o, 0);
        chk("R1", "rst in reset", soft_rst_o, 0);
        chk("R1", "stage in reset", rd_stage, 0);
        rst_n = 1'b1;
        idle(40);
        chk("R1", "mode after reset", rd_mode, 0);

        // full escalation, length 1, all stages
        cyc(1'b1, 1, 3, 1'b0);
        idle(3 * 16 + 10);
        chk("R6", "final stage held", rd_stage, 3);
        chk("R10", "nmi flag bit", int'(rd_stage[1]), 1);

        // exact period boundary, mode 1
        cyc(1'b1, 2, 1, 1'b0);
        idle(31);
        chk("R3", "irq before period end", irq_o, 0);
        idle(1);
        chk("R3", "irq at period end", irq_o, 1);
        idle(40);
        chk("R7", "mode1 cap", rd_stage, 1);

        // mode 2 cap
        cyc(1'b1, 1, 2, 1'b0);
        idle(60);
        chk("R7", "mode2 cap", rd_stage, 2);
        chk("R7", "mode2 no reset", soft_rst_o, 0);

        // mode 0 disabled
        cyc(1'b1, 1, 0, 1'b0);
        idle(80);
        chk("R8", "off stage", rd_stage, 0);

        // poke restarts period
        cyc(1'b1, 1, 3, 1'b0);
        idle(20);
        cyc(1'b0, 0, 0, 1'b1);
        chk("R9", "poke clears", rd_stage, 0);
        idle(15);
        chk("R9", "irq before restart period", irq_o, 0);
        idle(1);
        chk("R9", "irq after restart period", irq_o, 1);

        // write and poke together
        cyc(1'b1, 1, 3, 1'b0);
        idle(20);
        cyc(1'b1, 3, 2, 1'b1);
        chk("R11", "len from write", rd_len, 3);
        chk("R11", "stage cleared", rd_stage, 0);
        idle(50);
        chk("R11", "new period used", irq_o, 1);

        // zero length
        cyc(1'b1, 0, 3, 1'b0);
        idle(4);
        chk("R3", "zero length period", rd_stage, 1);
        idle(8);
        chk("R3", "zero length final", rd_stage, 3);

        // random scenarios
        for (int s = 0; s < 60; s++) begin
            int L = int'($urandom_range(0, 3));
            int M = int'($urandom_range(0, 3));
            int n;
            cyc(1'b1, L, M, 1'b0);
            n = int'($urandom_range(10, 3 * per(L) + 20));
            for (int j = 0; j < n; j++) begin
                int r = int'($urandom_range(0, 99));
                if (r < 2)
                    cyc(1'b0, int'($urandom_range(0, 65535)), int'($urandom_range(0, 3)), 1'b1);
                else if (r < 3)
                    cyc(1'b1, int'($urandom_range(0, 3)), int'($urandom_range(0, 3)), r[0]);
                else
                    cyc(1'b0, int'($urandom_range(0, 65535)), int'($urandom_range(0, 3)), 1'b0);
            end
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule